// File: doc/BRIEF.md
# UDP Register Access Dispatcher

This block sits behind a UDP receive path that has already removed the Ethernet, IP and UDP headers. Each datagram arrives as a 16-bit word stream, with its destination port and source IP address alongside it. The block checks each datagram and turns an accepted one into a single register write or read.

The target of that access is either the board's own register space or one of four downstream front-end boards behind a bridge. The destination port picks both the operation and the target. A fixed access key at the head of the payload must match, or the datagram is discarded and an error counter advances.

A read produces a response record. This record carries the destination port of the matching response channel, the requester's IP address, the register address and the read data. The block then waits for that one transaction to finish before it accepts the next datagram. A downstream board that never answers is released after a timeout.

The block also derives the board's IP and MAC addresses from the crate and slot IDs on the backplane.

Top module: `udp_reg_dispatch`

## Requirements
- R1: `my_ip` equals 192.168.(100 + `crate_id`, modulo 256).(`slot_id`), with 192 in the top byte. It follows a change of the IDs within two clock cycles.
- R2: `my_mac` equals AA:BB:CC:DD:(`crate_id`):(`slot_id`), with AA in the top byte.
- R3: The payload is made of 16-bit words. Word 0 is the upper half of the key and word 1 is the lower half. Word 2 is the register address. Words 3 and 4 are the upper and lower halves of the write data.
- R4: Port 32000 writes a local register and port 32001 reads one, using the `loc_*` request interface.
- R5: Port 32000+100·Z (Z = 1..4) writes a register on downstream board Z, and port 32001+100·Z reads one. Both use the `fe_*` interface with `fe_sel` = Z−1.
- R6: A datagram whose key is not 0xDEADBEEF issues no register access and increments `err_count`.
- R7: A datagram to any other port issues no access and increments `err_count`. So does a read shorter than 3 words or a write shorter than 5 words.
- R8: A read ends with a one-cycle `rsp_valid`. The record has `rsp_port` = 32002+100·target (target 0 = local), `rsp_ip` = the datagram's source IP, `rsp_addr` = the register address and `rsp_data` = the read data, with `rsp_err` low.
- R9: A write produces no response record.
- R10: Only one access is outstanding at a time. `in_ready` stays low from the cycle after the last word until the access completes, and the request holds with stable fields until it is acknowledged.
- R11: An access not acknowledged within `TIMEOUT` cycles is abandoned and increments `err_count`. For a read, it responds with all-ones data and `rsp_err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crate_id | input | 8 | Backplane crate ID |
| slot_id | input | 8 | Backplane slot ID |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Block can take a payload word |
| in_data | input | 16 | Payload word |
| in_last | input | 1 | Last word of datagram |
| in_port | input | 16 | UDP destination port, valid with the first word |
| in_src_ip | input | 32 | Source IP, valid with the first word |
| loc_req | output | 1 | Local register request |
| loc_we | output | 1 | Local write (1) or read (0) |
| loc_addr | output | 16 | Local register address |
| loc_wdata | output | 32 | Local write data |
| loc_ack | input | 1 | Local acknowledge |
| loc_rdata | input | 32 | Local read data, valid with ack |
| fe_req | output | 1 | Downstream request |
| fe_sel | output | 2 | Downstream board index (Z−1) |
| fe_we | output | 1 | Downstream write (1) or read (0) |
| fe_addr | output | 16 | Downstream register address |
| fe_wdata | output | 32 | Downstream write data |
| fe_ack | input | 1 | Downstream acknowledge |
| fe_rdata | input | 32 | Downstream read data, valid with ack |
| rsp_valid | output | 1 | Response record valid (one cycle) |
| rsp_port | output | 16 | Response destination port |
| rsp_ip | output | 32 | Response destination IP |
| rsp_addr | output | 16 | Register address read |
| rsp_data | output | 32 | Read data or all ones |
| rsp_err | output | 1 | Timeout flag |
| my_ip | output | 32 | Derived board IP |
| my_mac | output | 48 | Derived board MAC |
| err_count | output | 8 | Saturating count of drops and timeouts |

## Verification
The bench sends a key that is wrong by a single bit. A design that compared only part of the key would then write the register, and a later read would return the new value instead of the old one.

It probes ports next to valid ones: 32002 and 32500. A decoder built on arithmetic ranges would treat these as accesses to a nonexistent board or to the response channel. The bench also sends a three-word write, which a design without a length check would turn into a write of stale data.

A downstream board that never acknowledges must come back as all-ones data with the error flag set. The response must go to that board's own response port. A design without a timeout would hang with `in_ready` low until the watchdog fired.

// File: rtl/udp_disp_pkg.sv
package udp_disp_pkg;
  localparam logic [31:0] SYS_KEY     = 32'hDEAD_BEEF;
  localparam int          PORT_BASE   = 32000;
  localparam int          PORT_STRIDE = 100;

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD} op_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] tgt;
  } dec_t;
endpackage

// File: rtl/udp_port_decode.sv
module udp_port_decode
  import udp_disp_pkg::*;
#(
  parameter int N_FE = 4
) (
  input  logic [15:0] port,
  output dec_t        dec
);
  localparam int N_TGT = N_FE + 1;

  always_comb begin
    dec = '{op: OP_NONE, tgt: 3'd0};
    for (int t = 0; t < N_TGT; t++) begin
      if (port == 16'(PORT_BASE + t * PORT_STRIDE))
        dec = '{op: OP_WR, tgt: 3'(t)};
      else if (port == 16'(PORT_BASE + t * PORT_STRIDE + 1))
        dec = '{op: OP_RD, tgt: 3'(t)};
    end
  end
endmodule

// File: rtl/udp_payload_collect.sv
module udp_payload_collect #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [15:0]       in_port,
  input  logic [31:0]       in_src_ip,
  output logic              done,
  output logic [15:0]       port,
  output logic [31:0]       src_ip,
  output logic [31:0]       key,
  output logic [15:0]       addr,
  output logic [31:0]       data,
  output logic [2:0]        len
);
  localparam logic [2:0] IDX_MAX = 3'd5;
  logic [2:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      done <= 1'b0;
      len  <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        if (idx == 3'd0) begin
          port   <= in_port;
          src_ip <= in_src_ip;
        end
        case (idx)
          3'd0:    key[31:16]  <= in_data;
          3'd1:    key[15:0]   <= in_data;
          3'd2:    addr        <= in_data;
          3'd3:    data[31:16] <= in_data;
          3'd4:    data[15:0]  <= in_data;
          default: ;
        endcase
        if (in_last) begin
          done <= 1'b1;
          len  <= (idx == IDX_MAX) ? IDX_MAX : idx + 3'd1;
          idx  <= '0;
        end else if (idx != IDX_MAX) begin
          idx <= idx + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/udp_addr_gen.sv
module udp_addr_gen #(
  parameter logic [7:0] IP_CRATE_OFS = 8'd100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  crate_id,
  input  logic [7:0]  slot_id,
  output logic [31:0] my_ip,
  output logic [47:0] my_mac
);
  always_ff @(posedge clk) begin
    if (rst) begin
      my_ip  <= '0;
      my_mac <= '0;
    end else begin
      my_ip  <= {8'd192, 8'd168, crate_id + IP_CRATE_OFS, slot_id};
      my_mac <= {32'hAABB_CCDD, crate_id, slot_id};
    end
  end
endmodule

// File: rtl/udp_reg_dispatch.sv
module udp_reg_dispatch
  import udp_disp_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int ERR_W   = 8,
  parameter int N_FE    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  crate_id,
  input  logic [7:0]  slot_id,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  input  logic        in_last,
  input  logic [15:0] in_port,
  input  logic [31:0] in_src_ip,
  output logic        loc_req,
  output logic        loc_we,
  output logic [15:0] loc_addr,
  output logic [31:0] loc_wdata,
  input  logic        loc_ack,
  input  logic [31:0] loc_rdata,
  output logic        fe_req,
  output logic [1:0]  fe_sel,
  output logic        fe_we,
  output logic [15:0] fe_addr,
  output logic [31:0] fe_wdata,
  input  logic        fe_ack,
  input  logic [31:0] fe_rdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_port,
  output logic [31:0] rsp_ip,
  output logic [15:0] rsp_addr,
  output logic [31:0] rsp_data,
  output logic        rsp_err,
  output logic [31:0] my_ip,
  output logic [47:0] my_mac,
  output logic [ERR_W-1:0] err_count
);
  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT - 1);

  typedef enum logic {S_IDLE, S_BUSY} state_e;
  state_e state;

  logic        dg_done;
  logic [15:0] dg_port, dg_addr;
  logic [31:0] dg_src, dg_key, dg_data;
  logic [2:0]  dg_len;
  dec_t        dec;

  logic [2:0]  cur_tgt;
  logic        cur_we;
  logic [31:0] cur_src;
  logic [TO_W-1:0] to_cnt;
  logic        dg_ok, cur_ack;
  logic [31:0] cur_rdata;

  assign in_ready = (state == S_IDLE) && !dg_done;

  udp_addr_gen u_addr (
    .clk(clk), .rst(rst), .crate_id(crate_id), .slot_id(slot_id),
    .my_ip(my_ip), .my_mac(my_mac)
  );

  udp_payload_collect #(.WORD_W(16)) u_collect (
    .clk(clk), .rst(rst), .take(in_valid && in_ready),
    .in_data(in_data), .in_last(in_last), .in_port(in_port),
    .in_src_ip(in_src_ip), .done(dg_done), .port(dg_port),
    .src_ip(dg_src), .key(dg_key), .addr(dg_addr), .data(dg_data),
    .len(dg_len)
  );

  udp_port_decode #(.N_FE(N_FE)) u_dec (.port(dg_port), .dec(dec));

  always_comb begin
    dg_ok = (dec.op != OP_NONE) && (dg_key == SYS_KEY) &&
            (dg_len >= ((dec.op == OP_WR) ? 3'd5 : 3'd3));
    cur_ack   = (cur_tgt == 3'd0) ? loc_ack   : fe_ack;
    cur_rdata = (cur_tgt == 3'd0) ? loc_rdata : fe_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      loc_req   <= 1'b0;
      fe_req    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      err_count <= '0;
      to_cnt    <= '0;
      cur_tgt   <= '0;
      cur_we    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (dg_done) begin
          if (dg_ok) begin
            state     <= S_BUSY;
            cur_tgt   <= dec.tgt;
            cur_we    <= (dec.op == OP_WR);
            cur_src   <= dg_src;
            to_cnt    <= '0;
            loc_we    <= (dec.op == OP_WR);
            loc_addr  <= dg_addr;
            loc_wdata <= dg_data;
            fe_we     <= (dec.op == OP_WR);
            fe_addr   <= dg_addr;
            fe_wdata  <= dg_data;
            fe_sel    <= 2'(dec.tgt - 3'd1);
            loc_req   <= (dec.tgt == 3'd0);
            fe_req    <= (dec.tgt != 3'd0);
          end else if (err_count != '1) begin
            err_count <= err_count + 1'b1;
          end
        end
        S_BUSY: begin
          if (cur_ack || to_cnt == TO_LAST) begin
            state    <= S_IDLE;
            loc_req  <= 1'b0;
            fe_req   <= 1'b0;
            rsp_port <= 16'(PORT_BASE + 2) + 16'(cur_tgt) * 16'(PORT_STRIDE);
            rsp_ip   <= cur_src;
            rsp_addr <= loc_addr;
            rsp_valid <= !cur_we;
            rsp_err  <= !cur_ack;
            rsp_data <= cur_ack ? cur_rdata : '1;
            if (!cur_ack && err_count != '1) err_count <= err_count + 1'b1;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(loc_req && fe_req)); // R10
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (loc_req || fe_req) |-> !in_ready); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fe_req && !fe_ack && to_cnt != TO_LAST) |=> (fe_req && $stable(fe_addr) && $stable(fe_sel))); // R10
  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == 32'hFFFF_FFFF)); // R11
  AST_BAD_KEY_DROP: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && dg_done && dg_key != SYS_KEY) |=> (!loc_req && !fe_req)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/udp_reg_dispatch_test.sv
module udp_reg_dispatch_test;
  localparam int TO = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]  crate_id = 8'd5, slot_id = 8'd3;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [15:0] in_data = '0, in_port = '0;
  logic [31:0] in_src_ip = '0;
  logic        loc_req, loc_we, loc_ack = 1'b0;
  logic [15:0] loc_addr;
  logic [31:0] loc_wdata, loc_rdata = '0;
  logic        fe_req, fe_we, fe_ack = 1'b0;
  logic [1:0]  fe_sel;
  logic [15:0] fe_addr;
  logic [31:0] fe_wdata, fe_rdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_port, rsp_addr;
  logic [31:0] rsp_ip, rsp_data, my_ip;
  logic [47:0] my_mac;
  logic [7:0]  err_count;

  udp_reg_dispatch #(.TIMEOUT(TO)) uut (.*);

  int n_tests = 0, n_fail = 0;
  logic [31:0] lmem [16];
  logic [31:0] fmem [4][16];
  logic fe_alive = 1'b1;
  logic [1:0] seen_sel = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // register responders: ack two cycles after a request appears
  initial begin
    int ld = 0, fd = 0;
    forever begin
      @(negedge clk);
      if (loc_ack) loc_ack = 1'b0;
      else if (loc_req) begin
        ld++;
        if (ld == 2) begin
          ld = 0;
          loc_ack = 1'b1;
          if (loc_we) lmem[loc_addr[3:0]] = loc_wdata;
          else loc_rdata = lmem[loc_addr[3:0]];
        end
      end
      if (fe_ack) fe_ack = 1'b0;
      else if (fe_req) begin
        seen_sel = fe_sel;
        fd++;
        if (fd == 2 && fe_alive) begin
          fd = 0;
          fe_ack = 1'b1;
          if (fe_we) fmem[fe_sel][fe_addr[3:0]] = fe_wdata;
          else fe_rdata = fmem[fe_sel][fe_addr[3:0]];
        end
      end else fd = 0;
    end
  end

  task automatic send(input logic [15:0] p, input logic [31:0] src, input logic [31:0] key,
                      input logic [15:0] a, input logic [31:0] d, input int nw);
    logic [15:0] w [5];
    w[0] = key[31:16]; w[1] = key[15:0]; w[2] = a; w[3] = d[31:16]; w[4] = d[15:0];
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = w[i]; in_last = (i == nw - 1);
      in_port = p; in_src_ip = src;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // waits for a response; got=0 if none within the window
  task automatic wait_rsp(output bit got, output logic [15:0] p, output logic [31:0] ip,
                          output logic [15:0] a, output logic [31:0] d, output logic e);
    got = 0; p = '0; ip = '0; a = '0; d = '0; e = 1'b0;
    for (int i = 0; i < TO + 40; i++) begin
      if (rsp_valid) begin
        got = 1; p = rsp_port; ip = rsp_ip; a = rsp_addr; d = rsp_data; e = rsp_err;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [15:0] p, input logic [31:0] src, input logic [15:0] a,
                         input logic [15:0] exp_port, input logic [31:0] exp_d, input logic exp_e,
                         input string req);
    bit got; logic [15:0] rp, ra; logic [31:0] rip, rd; logic re;
    send(p, src, 32'hDEADBEEF, a, 32'h0, 3);
    wait_rsp(got, rp, rip, ra, rd, re);
    chk(got, {req, " response seen"}, 64'(got), 64'd1);
    chk(rp == exp_port, {req, " rsp_port"}, 64'(rp), 64'(exp_port));
    chk(rip == src && ra == a, {req, " rsp ip/addr"}, {rip, 16'h0, ra}, {src, 16'h0, a});
    chk(rd == exp_d && re == exp_e, {req, " rsp data/err"}, {31'h0, re, rd}, {31'h0, exp_e, exp_d});
  endtask

  task automatic write_no_rsp(input logic [15:0] p, input logic [31:0] key, input logic [15:0] a,
                              input logic [31:0] d, input int nw);
    bit got; logic [15:0] rp, ra; logic [31:0] rip, rd; logic re;
    send(p, 32'h0A000001, key, a, d, nw);
    wait_rsp(got, rp, rip, ra, rd, re);
    chk(!got, "R9 write gives no response", 64'(got), 64'd0);
  endtask

  task automatic t_reset;
    chk(!rsp_valid && !loc_req && !fe_req && in_ready, "R10 idle after reset",
        {rsp_valid, loc_req, fe_req, in_ready}, 64'h1);
    chk(err_count == 0, "R6 err_count reset", 64'(err_count), 64'd0);
  endtask

  task automatic t_addr;
    chk(my_ip == 32'hC0A8_6903, "R1 ip crate5 slot3", 64'(my_ip), 64'hC0A86903);
    chk(my_mac == 48'hAABBCCDD0503, "R2 mac crate5 slot3", 64'(my_mac), 64'hAABBCCDD0503);
    @(negedge clk); crate_id = 8'd7; slot_id = 8'd12;
    repeat (2) @(negedge clk);
    chk(my_ip == 32'hC0A8_6B0C, "R1 ip crate7 slot12", 64'(my_ip), 64'hC0A86B0C);
    chk(my_mac == 48'hAABBCCDD070C, "R2 mac crate7 slot12", 64'(my_mac), 64'hAABBCCDD070C);
  endtask

  task automatic t_local;
    write_no_rsp(16'd32000, 32'hDEADBEEF, 16'd5, 32'h12345678, 5);
    chk(lmem[5] == 32'h12345678, "R4 local write R3", 64'(lmem[5]), 64'h12345678);
    do_read(16'd32001, 32'hC0A80101, 16'd5, 16'd32002, 32'h12345678, 1'b0, "R4 R8 local read");
  endtask

  task automatic t_fe;
    write_no_rsp(16'd32300, 32'hDEADBEEF, 16'd7, 32'hCAFEF00D, 5);
    chk(fmem[2][7] == 32'hCAFEF00D, "R5 board3 write", 64'(fmem[2][7]), 64'hCAFEF00D);
    chk(seen_sel == 2'd2, "R5 fe_sel board3", 64'(seen_sel), 64'd2);
    fmem[0][1] = 32'h0BADF00D;
    do_read(16'd32101, 32'hC0A80202, 16'd1, 16'd32102, 32'h0BADF00D, 1'b0, "R5 R8 board1 read");
    chk(seen_sel == 2'd0, "R5 fe_sel board1", 64'(seen_sel), 64'd0);
  endtask

  task automatic t_drops;
    write_no_rsp(16'd32000, 32'hDEADBEEE, 16'd5, 32'h11111111, 5);
    chk(err_count == 1, "R6 bad key counted", 64'(err_count), 64'd1);
    write_no_rsp(16'd32002, 32'hDEADBEEF, 16'd5, 32'h22222222, 5);
    chk(err_count == 2, "R7 port 32002 counted", 64'(err_count), 64'd2);
    write_no_rsp(16'd32500, 32'hDEADBEEF, 16'd5, 32'h33333333, 5);
    chk(err_count == 3, "R7 port 32500 counted", 64'(err_count), 64'd3);
    write_no_rsp(16'd32000, 32'hDEADBEEF, 16'd5, 32'h44444444, 3);
    chk(err_count == 4, "R7 short write counted", 64'(err_count), 64'd4);
    do_read(16'd32001, 32'hC0A80303, 16'd5, 16'd32002, 32'h12345678, 1'b0, "R6 R7 reg unchanged");
  endtask

  task automatic t_timeout;
    bit got; logic [15:0] rp, ra; logic [31:0] rip, rd; logic re;
    fe_alive = 1'b0;
    send(16'd32401, 32'hC0A80404, 32'hDEADBEEF, 16'd9, 32'h0, 3);
    repeat (5) @(negedge clk);
    chk(!in_ready && fe_req, "R10 busy blocks input", {in_ready, fe_req}, 64'h1);
    wait_rsp(got, rp, rip, ra, rd, re);
    chk(got && rd == 32'hFFFFFFFF && re, "R11 timeout data/err", {re, rd}, 64'h1FFFFFFFF);
    chk(rp == 16'd32402, "R11 timeout rsp_port", 64'(rp), 64'd32402);
    @(negedge clk);
    chk(err_count == 5, "R11 timeout counted", 64'(err_count), 64'd5);
    chk(in_ready, "R10 ready after timeout", 64'(in_ready), 64'd1);
    fe_alive = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      lmem[i] = '0;
      for (int b = 0; b < 4; b++) fmem[b][i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_addr();
    t_local();
    t_fe();
    t_drops();
    t_timeout();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule